// File: doc/BRIEF.md
# Cyclic-Shift Switch-Setting Generator for a Rearrangeable Binary Network

This block computes the complete set of switch settings for a rearrangeable binary network of 2^n lines built from two-state 2x2 switches in 2n-1 stages. It covers one family of routings: a cyclic rotation by an amount k, x -> (x + k) mod S. The rotation acts either on the whole vector (S = 2^n) or independently inside every aligned segment of S = 2^(n-j) consecutive lines. The network size n is the parameter `LOG_N`. The segment parameter j and the amount k are sampled on a start strobe.

The generator works by recursive halving. For any subnetwork carrying a rotation, its input stage is left straight. Its output stage is set uniformly to the low bit of the rotation. The two half-size subnetworks inside it receive rotations of floor(k/2) (upper) and floor(k/2) + (k mod 2) (lower), each reduced modulo the halved segment. One recursion depth is handled per clock. All subnetwork rotations of the current depth are held side by side in a register array and split in parallel. After n cycles the full vector is valid and a one-cycle completion pulse is raised.

The controller is a three-state machine. **ST_IDLE** waits for `start` and, on **IDLE->RUN**, captures the operands and clears the vector. **ST_RUN** writes one stage column per cycle, staying in RUN (**RUN->RUN**) until the middle stage is written, then takes **RUN->DONE**. **ST_DONE** pulses `done` for one cycle and always takes **DONE->IDLE**. Reset forces ST_IDLE from any state.

Top module: `bsc_shift_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is applied and right after it, `busy` and `done` are 0 and every bit of `sw_ctrl` is 0.
- R2: A `start` sampled high in ST_IDLE makes `busy` high for exactly `LOG_N` cycles. `done` is then high for exactly one cycle, with `busy` low. Seen from the falling edge on which `start` is driven, `done` is first visible `LOG_N`+1 falling edges later.
- R3: `start` is ignored while `busy` or `done` is high. The finished vector reflects only the operands captured at the accepted start.
- R4: Layout of `sw_ctrl`. Bit s*2^(n-1)+i drives switch i of stage s, where stage 0 is the input side: 0 means straight and 1 means crossed. At recursion depth d, subnetwork c owns lines c*2^(n-d) and upward. In its input stage, switch i takes local lines 2i and 2i+1 and sends its upper output to the upper child (child 2c) on line i and its lower output to the lower child (child 2c+1) on line i. Its output stage (stage 2n-2-d) mirrors that wiring. The middle stage n-1 holds the single switches of the 2-line subnetworks.
- R5: Every switch in stages 0 through n-2 is straight.
- R6: For S > 1, every switch of the final stage 2n-2 equals bit 0 of (k mod S).
- R7: With j = 0, routing input x through the network lands it on output (x + k) mod 2^n, for every k.
- R8: With 0 < j < n, input x = b + r (b a multiple of S, r < S) lands on output b + ((r + k) mod S).
- R9: A j value of n or more gives the identity: all switches straight.
- R10: After `done`, `sw_ctrl` stays unchanged until the next accepted `start`, whatever the other inputs do.
- R11: Bits of k at or above position n-j have no effect on the result.
- R12: Reset in the middle of a computation aborts it: `busy` drops and `sw_ctrl` returns to all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted in ST_IDLE only |
| seg_j | input | $clog2(LOG_N+1) | Segment parameter j; segment size is 2^(LOG_N-j) |
| shift_k | input | LOG_N | Rotation amount k |
| busy | output | 1 | High while stage columns are being written |
| done | output | 1 | One-cycle completion pulse |
| sw_ctrl | output | (2*LOG_N-1)*2^(LOG_N-1) | Switch settings, layout per R4 |

## Verification
Several properties are checked on every cycle. `done` is a single-cycle pulse that never coincides with `busy`. Each run lasts exactly `LOG_N` busy cycles. An accepted computation is never aborted by a second strobe. The input-side half of the vector is straight when `done` is reported. The vector does not move while the controller sits idle without a strobe.

Whether the vector actually realises the requested rotation can only be shown by the bench scenarios. The bench routes an index vector through a model of the wiring and sweeps every k and every j for n = 3 and n = 4. The scenarios also cover the independence from high k bits, the ignored second strobe and the mid-run reset.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bsc_state_e;
endpackage

// File: rtl/bsc_split.sv
// Derives one child subnetwork rotation from its parent rotation.
module bsc_split #(
    parameter int KW = 4
) (
    input  logic [KW-1:0] parent,
    input  logic          take_carry,
    input  logic [KW-1:0] keep,
    output logic [KW-1:0] child
);
    logic [KW-1:0] half_amt;
    logic [KW-1:0] carry_in;

    always_comb begin
        half_amt = parent >> 1;
        carry_in = {{(KW-1){1'b0}}, parent[0] & take_carry};
        child    = (half_amt + carry_in) & keep;
    end
endmodule

// File: rtl/bsc_column.sv
// Builds the output-stage column for the current recursion depth.
module bsc_column #(
    parameter int LOG_N = 4,
    parameter int H     = 1 << (LOG_N - 1),
    parameter int DW    = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
    input  logic [H-1:0][LOG_N-1:0] kv,
    input  logic [DW-1:0]           depth,
    output logic [H-1:0]            col
);
    localparam int HW = (H > 1) ? $clog2(H) : 1;

    always_comb begin
        for (int i = 0; i < H; i++) begin
            automatic int          sh  = LOG_N - 1 - int'(depth);
            automatic logic [HW-1:0] sub = HW'(i >> sh);
            col[i] = kv[sub][0];
        end
    end
endmodule

// File: rtl/bsc_shift_ctrl.sv
module bsc_shift_ctrl
    import bsc_pkg::*;
#(
    parameter int LOG_N = 4,
    localparam int H   = 1 << (LOG_N - 1),
    localparam int CW  = (2 * LOG_N - 1) * H,
    localparam int JW  = $clog2(LOG_N + 1),
    localparam int DW  = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [JW-1:0]    seg_j,
    input  logic [LOG_N-1:0] shift_k,
    output logic             busy,
    output logic             done,
    output logic [CW-1:0]    sw_ctrl
);
    bsc_state_e state, state_nx;

    logic [DW-1:0]              depth;
    logic [JW-1:0]              seg_w;
    logic [H-1:0][LOG_N-1:0]    kreg;
    logic [H-1:0][LOG_N-1:0]    kchild;
    logic [H-1:0]               col;
    logic [CW-1:0]              ctrl_q;
    logic                       last_lvl;
    logic [JW-1:0]              j_clamp;
    logic [JW-1:0]              w_first;
    logic [JW-1:0]              w_next;
    int                         col_base;

    function automatic logic [LOG_N-1:0] low_mask(input logic [JW-1:0] w);
        logic [LOG_N-1:0] m;
        for (int b = 0; b < LOG_N; b++) m[b] = (b < int'(w));
        return m;
    endfunction

    always_comb begin
        j_clamp  = (seg_j > JW'(LOG_N)) ? JW'(LOG_N) : seg_j;
        w_first  = JW'(LOG_N) - j_clamp;
        w_next   = (seg_w == '0) ? '0 : seg_w - 1'b1;
        last_lvl = (depth == DW'(LOG_N - 1));
        col_base = last_lvl ? (LOG_N - 1) * H : (2 * LOG_N - 2 - int'(depth)) * H;
    end

    for (genvar s = 0; s < H; s++) begin : g_split
        bsc_split #(.KW(LOG_N)) u_split (
            .parent     (kreg[s / 2]),
            .take_carry ((s % 2) == 1),
            .keep       (low_mask(w_next)),
            .child      (kchild[s])
        );
    end

    bsc_column #(.LOG_N(LOG_N), .H(H), .DW(DW)) u_column (
        .kv    (kreg),
        .depth (depth),
        .col   (col)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)    state_nx = ST_RUN;
            ST_RUN:  if (last_lvl) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath: rotation registers and switch columns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            kreg   <= '0;
            depth  <= '0;
            seg_w  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ctrl_q  <= '0;
                        kreg    <= '0;
                        kreg[0] <= shift_k & low_mask(w_first);
                        depth   <= '0;
                        seg_w   <= w_first;
                    end
                end
                ST_RUN: begin
                    ctrl_q[col_base +: H] <= col;
                    if (!last_lvl) begin
                        kreg  <= kchild;
                        depth <= depth + 1'b1;
                        seg_w <= w_next;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state == ST_RUN);
        done    = (state == ST_DONE);
        sw_ctrl = ctrl_q;
    end
endmodule

// File: rtl/bsc_shift_ctrl_chk.sv
module bsc_shift_ctrl_chk #(
    parameter int LOG_N = 4,
    localparam int H  = 1 << (LOG_N - 1),
    localparam int CW = (2 * LOG_N - 1) * H
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] sw_ctrl
);
    logic [7:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 8'd1;
        else           run_cnt <= '0;
    end

    // R2: completion is a single-cycle pulse
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: busy and done never overlap
    a_r2_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    // R2: each run lasts exactly LOG_N busy cycles
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt == 8'(LOG_N)));

    // R3: a strobe during a run does not abort it
    a_r3_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R5: input-side stages are straight when the result is reported
    a_r5_first_half_straight: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sw_ctrl[(LOG_N-1)*H-1:0] == '0));

    // R10: vector is frozen while idle without a strobe
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(sw_ctrl));
endmodule

bind bsc_shift_ctrl bsc_shift_ctrl_chk #(.LOG_N(LOG_N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .sw_ctrl (sw_ctrl)
);

// File: tb/bsc_shift_ctrl_test.sv
`timescale 1ns/1ps
module bsc_shift_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        st3 = 0, st4 = 0;
    logic [1:0]  j3 = 0;
    logic [2:0]  j4 = 0;
    logic [2:0]  k3 = 0;
    logic [3:0]  k4 = 0;
    logic        busy3, done3, busy4, done4;
    logic [19:0] c3;
    logic [55:0] c4;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    bsc_shift_ctrl #(.LOG_N(4)) uut (
        .clk(clk), .rst_n(rst_n), .start(st4), .seg_j(j4), .shift_k(k4),
        .busy(busy4), .done(done4), .sw_ctrl(c4));

    bsc_shift_ctrl #(.LOG_N(3)) uut_n3 (
        .clk(clk), .rst_n(rst_n), .start(st3), .seg_j(j3), .shift_k(k3),
        .busy(busy3), .done(done3), .sw_ctrl(c3));

    // j, k, probe input, expected output line (n = 4)
    localparam int TBL [9][4] = '{
        '{0,  5, 13,  2}, '{0, 15,  1,  0}, '{1,  3,  6,  1},
        '{1,  7, 12, 11}, '{2,  2,  7,  5}, '{3,  1,  9,  8},
        '{4,  9, 10, 10}, '{2, 13,  3,  0}, '{0,  0,  7,  7}};

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model of the wiring from R4: returns which input lands on each output line.
    task automatic route(input logic [55:0] cv, input int n, output int outv[16]);
        int data[16];
        int nxt[16];
        int hn;
        hn = 1 << (n - 1);
        for (int x = 0; x < 16; x++) begin data[x] = x; nxt[x] = 0; end
        for (int d = 0; d <= n - 2; d++) begin
            int l, hf;
            l = 1 << (n - d); hf = l / 2;
            for (int i = 0; i < hn; i++) begin
                int c, li, a, b;
                c = i / hf; li = i % hf;
                a = data[c*l + 2*li]; b = data[c*l + 2*li + 1];
                nxt[c*l + li]      = cv[d*hn + i] ? b : a;
                nxt[c*l + hf + li] = cv[d*hn + i] ? a : b;
            end
            data = nxt;
        end
        for (int i = 0; i < hn; i++) begin
            if (cv[(n-1)*hn + i]) begin
                int t;
                t = data[2*i]; data[2*i] = data[2*i+1]; data[2*i+1] = t;
            end
        end
        for (int d = n - 2; d >= 0; d--) begin
            int l, hf;
            l = 1 << (n - d); hf = l / 2;
            for (int i = 0; i < hn; i++) begin
                int c, li, up, lo;
                c = i / hf; li = i % hf;
                up = data[c*l + li]; lo = data[c*l + hf + li];
                nxt[c*l + 2*li]     = cv[(2*n-2-d)*hn + i] ? lo : up;
                nxt[c*l + 2*li + 1] = cv[(2*n-2-d)*hn + i] ? up : lo;
            end
            data = nxt;
        end
        outv = data;
    endtask

    task automatic verify_perm(input logic [55:0] cv, input int n, input int j,
                               input int k, input string req);
        int outv[16];
        int s, bad_y, bad_exp, nbad;
        route(cv, n, outv);
        s = (j >= n) ? 1 : (1 << (n - j));
        nbad = 0; bad_y = 0; bad_exp = 0;
        for (int y = 0; y < (1 << n); y++) begin
            int base, r, e;
            base = (y / s) * s; r = y % s;
            e = base + ((r + s - (k % s)) % s);
            if (outv[y] != e && nbad == 0) begin bad_y = y; bad_exp = e; end
            if (outv[y] != e) nbad++;
        end
        check(nbad == 0, req, $sformatf("n=%0d j=%0d k=%0d source at line %0d", n, j, k, bad_y),
              outv[bad_y], bad_exp);
    endtask

    task automatic run_op(input int n, input int j, input int k,
                          output logic [55:0] cv, output int lat);
        @(negedge clk);
        if (n == 4) begin j4 = 3'(j); k4 = 4'(k); st4 = 1; end
        else        begin j3 = 2'(j); k3 = 3'(k); st3 = 1; end
        @(negedge clk);
        st4 = 0; st3 = 0;
        lat = 1;
        while (!((n == 4) ? done4 : done3) && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        cv = (n == 4) ? c4 : {36'd0, c3};
    endtask

    initial begin
        #750000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [55:0] cv, cv2;
        int lat;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(busy4 == 0 && done4 == 0, "R1", "n4 busy/done", {busy4, done4}, 0);
        check(c4 == 0, "R1", "n4 sw_ctrl", c4, 0);
        check(busy3 == 0 && done3 == 0 && c3 == 0, "R1", "n3 outputs", c3, 0);
        rst_n = 1;
        @(negedge clk);
        check(busy4 == 0 && c4 == 0, "R1", "n4 after release", c4, 0);

        // R4 table of probes
        for (int t = 0; t < 9; t++) begin
            int outv[16];
            int where;
            run_op(4, TBL[t][0], TBL[t][1], cv, lat);
            route(cv, 4, outv);
            where = -1;
            for (int y = 0; y < 16; y++) if (outv[y] == TBL[t][2]) where = y;
            check(where == TBL[t][3], "R4", $sformatf("probe row %0d destination", t),
                  where, TBL[t][3]);
        end

        // full sweeps, R2 R5 R6 R7 R8 R9
        for (int n = 3; n <= 4; n++) begin
            for (int j = 0; j <= n; j++) begin
                for (int k = 0; k < (1 << n); k++) begin
                    int hn, s, lastb;
                    bit uni;
                    run_op(n, j, k, cv, lat);
                    hn = 1 << (n - 1);
                    s = 1 << (n - j);
                    check(lat == n + 1, "R2", "latency to done", lat, n + 1);
                    check((cv & ((56'd1 << ((n-1)*hn)) - 56'd1)) == 0, "R5",
                          "first half straight", cv, 0);
                    lastb = (s > 1) ? ((k % s) & 1) : 0;
                    uni = 1;
                    for (int i = 0; i < hn; i++)
                        if (cv[(2*n-2)*hn + i] != lastb[0]) uni = 0;
                    check(uni, "R6", $sformatf("final stage n=%0d j=%0d k=%0d", n, j, k),
                          cv[(2*n-2)*hn +: 8], lastb);
                    if (j == 0)      verify_perm(cv, n, j, k, "R7");
                    else if (j < n)  verify_perm(cv, n, j, k, "R8");
                    else             check(cv == 0, "R9", "identity at j=n", cv, 0);
                end
            end
        end

        // R9: j above n clamps to identity
        run_op(4, 7, 11, cv, lat);
        check(cv == 0, "R9", "j=7 identity", cv, 0);

        // R11: bits above the segment width have no effect
        run_op(4, 2, 13, cv, lat);
        run_op(4, 2, 1, cv2, lat);
        check(cv == cv2, "R11", "k=13 vs k=1 at j=2", cv, cv2);

        // R2: done is one cycle
        run_op(4, 0, 6, cv, lat);
        @(negedge clk);
        check(done4 == 0 && busy4 == 0, "R2", "done pulse width", done4, 0);

        // R10: hold after done with inputs wiggling
        j4 = 3'd2; k4 = 4'd9;
        repeat (10) @(negedge clk);
        check(c4 == cv, "R10", "vector held", c4, cv);

        // R3: second strobe while busy ignored
        @(negedge clk); j4 = 0; k4 = 5; st4 = 1;
        @(negedge clk); st4 = 1; j4 = 1; k4 = 3;
        @(negedge clk); st4 = 0;
        lat = 0;
        while (!done4 && lat < 50) begin @(negedge clk); lat++; end
        verify_perm(c4, 4, 0, 5, "R3");
        @(negedge clk);
        check(busy4 == 0, "R3", "no restart after done", busy4, 0);

        // R12: reset mid-run
        @(negedge clk); j4 = 0; k4 = 1; st4 = 1;
        @(negedge clk); st4 = 0;
        @(negedge clk);
        check(c4 != 0 && busy4 == 1, "R12", "partial vector before reset", c4, 1);
        rst_n = 0;
        @(negedge clk);
        check(busy4 == 0 && done4 == 0 && c4 == 0, "R12", "abort clears", c4, 0);
        rst_n = 1;
        run_op(4, 0, 3, cv, lat);
        verify_perm(cv, 4, 0, 3, "R12");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule